// File: doc/BRIEF.md
# Dual-Bit Adder Logic Element

This block is the arithmetic mode of a fracturable look-up-table element. Four 4-input LUT quarters each read a 16-bit slice of a configuration mask. Their outputs feed two dedicated one-bit full adders, so one element produces two registered sum bits. The carry ripples from the low adder into the high adder and then leaves the element. In the last stage of each quarter a multiplexer is steered by a lane-private input, so every one of the eight data inputs can take part in the arithmetic.

A shared mode changes what the high adder receives. Each lane's two quarters then see the same three lane-private inputs, and are programmed as a parity (sum) and a majority (carry-save) function. The majority term of a column is passed one bit position up: inside the element from lane 0 to lane 1, and between elements through a shift link. A chain of elements therefore adds three independent operands, two bits per element. The element at the bottom of the chain has its shift input tied low. The final shift output and the final carry output each carry the weight of the bit above the top sum bit.

Top module: `ale_dual_adder`

## Requirements
- R1: An active-low asynchronous reset clears `sum_q` to 0.
- R2: Quarter q (0..3) reads `lut_mask[16q+15:16q]` at the index {sel, c, b, lsb}, with lsb as the least significant bit. b is `din[1]`. Lane 0 owns quarters 0 and 1, with c = `din[2]`. Lane 1 owns quarters 2 and 3, with c = `din[3]`. The even quarter of lane k has sel = `din[4+k]`. The odd quarter of lane k has sel = `din[6+k]`. In normal mode lsb = `din[0]` for every quarter.
- R3: In normal mode (`shared_mode`=0), bit 0 adds z0, z1 and `carry_in`. Bit 1 adds z2, z3 and the carry from bit 0. `carry_out` is the carry of bit 1.
- R4: Sum bits appear on `sum_q` after the next rising clock edge. `carry_out` and `shift_out` follow the inputs combinationally.
- R5: In shared mode the even quarter of lane k takes `din[6+k]` as its lsb, and the odd quarter takes `din[4+k]` as its lsb.
- R6: In shared mode, bit 0 adds z0, `shift_in` and `carry_in`. Bit 1 adds z2, z1 and the carry from bit 0. `shift_out` equals z3.
- R7: In normal mode `shift_out` is 0 and `shift_in` has no effect on any output.
- R8: Take four elements in shared mode with the parity/majority masks and `din[1]`=0. Feed bit i of operands X, Y and W into lane i%2 of element i/2: X to c, Y to `din[4+k]`, W to `din[6+k]`. Chain the carry and shift links, with the bottom links set to 0. The 8 sum bits plus 256 times (top `carry_out` + top `shift_out`) then equal X+Y+W.
- R9: A `carry_in` of 1 adds one unit at bit 0, and the carry propagates through both bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lut_mask | input | 64 | Four 16-bit quarter masks |
| shared_mode | input | 1 | 1 selects three-operand shared arithmetic |
| din | input | 8 | Data inputs (mapping in R2) |
| carry_in | input | 1 | Carry into bit 0 |
| shift_in | input | 1 | Majority term from the element below |
| carry_out | output | 1 | Carry out of bit 1 |
| shift_out | output | 1 | Majority term passed to the element above |
| sum_q | output | 2 | Registered sum bits |

## Verification
The assertions assume that `lut_mask`, `shared_mode` and the data inputs are settled at each rising edge, since the carry and shift paths are purely combinational. The bench changes every input only on the falling edge and holds it for at least a full cycle. The carry generate and kill checks take the adder operands as they stand at the sampling edge, so glitches between edges are outside their scope. In shared-mode tests the shared input `din[1]` is held low, so the quarters behave as pure three-input functions.

// File: rtl/ale_pkg.sv
package ale_pkg;
    localparam int LUT_IN   = 4;
    localparam int MASK_W   = 1 << LUT_IN;
    localparam int LANES    = 2;
    localparam int QUARTERS = 2 * LANES;
    localparam int DIN_W    = 2 + 3 * LANES;

    typedef struct packed {
        logic [LANES-1:0] sum;
    } ale_state_t;
endpackage

// File: rtl/ale_lut_quarter.sv
module ale_lut_quarter
    import ale_pkg::*;
(
    input  logic [MASK_W-1:0] mask,
    input  logic [LUT_IN-1:0] idx,
    output logic              z
);
    always_comb begin
        z = mask[idx];
    end
endmodule

// File: rtl/ale_full_adder.sv
module ale_full_adder (
    input  logic x,
    input  logic y,
    input  logic ci,
    output logic s,
    output logic co
);
    always_comb begin
        s  = x ^ y ^ ci;
        co = (x & y) | (ci & (x ^ y));
    end
endmodule

// File: rtl/ale_dual_adder.sv
module ale_dual_adder
    import ale_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [QUARTERS*MASK_W-1:0] lut_mask,
    input  logic                       shared_mode,
    input  logic [DIN_W-1:0]           din,
    input  logic                       carry_in,
    input  logic                       shift_in,
    output logic                       carry_out,
    output logic                       shift_out,
    output logic [LANES-1:0]           sum_q
);
    logic [QUARTERS-1:0] z;
    logic [LANES-1:0]    op_x;
    logic [LANES-1:0]    op_y;
    logic [LANES-1:0]    sum_bits;
    logic [LANES:0]      carry;

    ale_state_t state_d;
    ale_state_t state_q;

    assign carry[0] = carry_in;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic lane_c;
        logic sel_lo;
        logic sel_hi;
        logic lsb_lo;
        logic lsb_hi;
        logic [LUT_IN-1:0] idx_lo;
        logic [LUT_IN-1:0] idx_hi;

        always_comb begin
            lane_c = din[2 + k];
            sel_lo = din[2 + LANES + k];
            sel_hi = din[2 + 2*LANES + k];
            // shared mode steers the other lane-private input into the lsb
            lsb_lo = shared_mode ? sel_hi : din[0];
            lsb_hi = shared_mode ? sel_lo : din[0];
            idx_lo = {sel_lo, lane_c, din[1], lsb_lo};
            idx_hi = {sel_hi, lane_c, din[1], lsb_hi};
        end

        ale_lut_quarter i_q_lo (
            .mask (lut_mask[(2*k)*MASK_W +: MASK_W]),
            .idx  (idx_lo),
            .z    (z[2*k])
        );

        ale_lut_quarter i_q_hi (
            .mask (lut_mask[(2*k+1)*MASK_W +: MASK_W]),
            .idx  (idx_hi),
            .z    (z[2*k+1])
        );

        if (k == 0) begin : g_bottom
            always_comb begin
                op_x[k] = z[2*k];
                op_y[k] = shared_mode ? shift_in : z[2*k+1];
            end
        end else begin : g_upper
            always_comb begin
                op_x[k] = z[2*k];
                op_y[k] = shared_mode ? z[2*k-1] : z[2*k+1];
            end
        end

        ale_full_adder i_fa (
            .x  (op_x[k]),
            .y  (op_y[k]),
            .ci (carry[k]),
            .s  (sum_bits[k]),
            .co (carry[k+1])
        );
    end

    always_comb begin
        carry_out = carry[LANES];
        shift_out = shared_mode & z[QUARTERS-1];
    end

    always_comb begin
        state_d     = state_q;
        state_d.sum = sum_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign sum_q = state_q.sum;

    AST_CARRY_GENERATE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_x[LANES-1] && op_y[LANES-1]) |-> carry_out); // R3
    AST_CARRY_KILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_x[LANES-1] && !op_y[LANES-1]) |-> !carry_out); // R9
    AST_SUM_REGISTERED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (sum_q[0] == $past(op_x[0] ^ op_y[0] ^ carry_in))); // R4
    AST_SHIFT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !shared_mode |-> !shift_out); // R7
    AST_SHIFT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (shared_mode && shift_out) |-> z[QUARTERS-1]); // R6
endmodule

// File: tb/test_ale_dual_adder.sv
`timescale 1ns/1ps
module test_ale_dual_adder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] lut_mask = '0;
    logic        shared_mode = 1'b0;
    logic [7:0]  din = '0;
    logic        carry_in = 1'b0;
    logic        shift_in = 1'b0;
    logic        carry_out;
    logic        shift_out;
    logic [1:0]  sum_q;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    ale_dual_adder i_ale_dual_adder (
        .clk(clk), .rst_n(rst_n), .lut_mask(lut_mask), .shared_mode(shared_mode),
        .din(din), .carry_in(carry_in), .shift_in(shift_in),
        .carry_out(carry_out), .shift_out(shift_out), .sum_q(sum_q)
    );

    // four-element chain for the three-operand sum
    logic [7:0]  op_x = '0;
    logic [7:0]  op_y = '0;
    logic [7:0]  op_w = '0;
    logic [63:0] ch_mask = '0;
    logic [4:0]  ch_c;
    logic [4:0]  ch_s;
    logic [7:0]  ch_sum;
    assign ch_c[0] = 1'b0;
    assign ch_s[0] = 1'b0;

    for (genvar j = 0; j < 4; j++) begin : g_chain
        logic [7:0] ch_din;
        assign ch_din = {op_w[2*j+1], op_w[2*j], op_y[2*j+1], op_y[2*j],
                         op_x[2*j+1], op_x[2*j], 1'b0, 1'b0};
        ale_dual_adder i_elem (
            .clk(clk), .rst_n(rst_n), .lut_mask(ch_mask), .shared_mode(1'b1),
            .din(ch_din), .carry_in(ch_c[j]), .shift_in(ch_s[j]),
            .carry_out(ch_c[j+1]), .shift_out(ch_s[j+1]), .sum_q(ch_sum[2*j +: 2])
        );
    end

    function automatic logic [15:0] mk_parity();
        logic [15:0] m;
        for (int i = 0; i < 16; i++) m[i] = i[3] ^ i[2] ^ i[0];
        return m;
    endfunction

    function automatic logic [15:0] mk_majority();
        logic [15:0] m;
        for (int i = 0; i < 16; i++) m[i] = (i[3] & i[2]) | (i[3] & i[0]) | (i[2] & i[0]);
        return m;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // drive on falling edge, sample comb mid-cycle, sums after next rise
    task automatic apply(input logic [63:0] m, input logic sh, input logic [7:0] d,
                         input logic ci, input logic si,
                         output logic co, output logic so, output logic [1:0] s);
        @(negedge clk);
        lut_mask = m; shared_mode = sh; din = d; carry_in = ci; shift_in = si;
        #1;
        co = carry_out; so = shift_out;
        @(posedge clk);
        @(negedge clk);
        s = sum_q;
    endtask

    // {din, carry_in, shift_in, expected {carry_out, sum}}; normal mode, lane adds c + f
    localparam logic [12:0] VEC [6] = '{
        {8'h00, 1'b0, 1'b0, 3'b000},
        {8'h44, 1'b0, 1'b0, 3'b010},
        {8'hCC, 1'b1, 1'b1, 3'b111},
        {8'h48, 1'b1, 1'b0, 3'b100},
        {8'h3F, 1'b1, 1'b1, 3'b100},
        {8'h84, 1'b0, 1'b0, 3'b011}
    };

    logic       wd_done = 1'b0;

    initial begin
        repeat (150000) @(posedge clk);
        if (!wd_done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic co, so;
        logic [1:0] s;
        logic [63:0] m_norm, m_shared;
        m_norm   = {16'hFF00, 16'hF0F0, 16'hFF00, 16'hF0F0};
        m_shared = {mk_majority(), mk_parity(), mk_majority(), mk_parity()};

        // R1: reset state
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 reset sum", sum_q, 0);
        rst_n = 1'b1;

        // R3 R7 R9 R4: vector table in normal mode
        for (int v = 0; v < 6; v++) begin
            apply(m_norm, 1'b0, VEC[v][12:5], VEC[v][4], VEC[v][3], co, so, s);
            check("R3 table sum", s, VEC[v][1:0]);
            check("R9 table carry_out", co, VEC[v][2]);
            check("R7 shift_out idle", so, 0);
        end

        // R4: sum held until the clock, carry comb
        @(negedge clk);
        lut_mask = m_norm; shared_mode = 1'b0; din = 8'h44; carry_in = 1'b0;
        @(posedge clk); @(negedge clk);
        din = 8'hCC; carry_in = 1'b1;
        #1;
        check("R4 sum before edge", sum_q, 2);
        check("R4 carry comb", carry_out, 1);
        @(posedge clk); @(negedge clk);
        check("R4 sum after edge", sum_q, 3);

        // R2: lsb (a) addressing of quarter 0
        apply({48'h0, 16'hAAAA}, 1'b0, 8'h01, 1'b0, 1'b0, co, so, s);
        check("R2 lsb addressing", s, 1);
        // R2: sel of even quarter lane 0 is din[4]
        apply({48'h0, 16'hFF00}, 1'b0, 8'h10, 1'b0, 1'b0, co, so, s);
        check("R2 sel din4", s, 1);
        // R2: b input of lane 1 even quarter (mask bit1 pattern)
        apply({16'h0, 16'hCCCC, 32'h0}, 1'b0, 8'h02, 1'b0, 1'b0, co, so, s);
        check("R2 b addressing lane1", s, 2);
        // R7: shift_in ignored in normal mode
        apply(m_norm, 1'b0, 8'h00, 1'b0, 1'b1, co, so, s);
        check("R7 shift_in ignored", {co, so, s}, 0);

        // R5 R6: single element shared mode, exhaustive over lanes
        for (int x = 0; x < 4; x++)
            for (int y = 0; y < 4; y++)
                for (int w = 0; w < 4; w++) begin
                    int sbit0, mj0, sbit1, mj1, b0, b1, c1, exp_s, exp_c;
                    logic [7:0] d;
                    int sin;
                    sin = (x + y + w) % 2;
                    d = {w[1], w[0], y[1], y[0], x[1], x[0], 2'b00};
                    sbit0 = x[0] ^ y[0] ^ w[0];
                    mj0   = (x[0] + y[0] + w[0]) >= 2 ? 1 : 0;
                    sbit1 = x[1] ^ y[1] ^ w[1];
                    mj1   = (x[1] + y[1] + w[1]) >= 2 ? 1 : 0;
                    b0 = sbit0 + sin + 1;
                    b1 = sbit1 + mj0 + b0 / 2;
                    c1 = b1 / 2;
                    exp_s = (b1 % 2) * 2 + (b0 % 2);
                    exp_c = c1;
                    apply(m_shared, 1'b1, d, 1'b1, sin[0], co, so, s);
                    check("R5 R6 shared sum", s, exp_s);
                    check("R6 shared carry_out", co, exp_c);
                    check("R6 shift_out majority", so, mj1);
                end

        // R8: three-operand chain, directed extremes then random
        ch_mask = m_shared;
        for (int t = 0; t < 203; t++) begin
            int res;
            @(negedge clk);
            if (t == 0)      begin op_x = 8'hFF; op_y = 8'hFF; op_w = 8'hFF; end
            else if (t == 1) begin op_x = 8'h00; op_y = 8'h00; op_w = 8'h00; end
            else if (t == 2) begin op_x = 8'h80; op_y = 8'h80; op_w = 8'h7F; end
            else begin
                op_x = 8'($urandom); op_y = 8'($urandom); op_w = 8'($urandom);
            end
            #1;
            res = 256 * (int'(ch_c[4]) + int'(ch_s[4]));
            @(posedge clk); @(negedge clk);
            res += int'(ch_sum);
            check("R8 three-operand sum", res, int'(op_x) + int'(op_y) + int'(op_w));
        end

        // R1: asynchronous reset mid-run
        @(negedge clk);
        lut_mask = m_norm; shared_mode = 1'b0; din = 8'hCC; carry_in = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R1 pre-reset nonzero", sum_q, 3);
        #1 rst_n = 1'b0;
        #1;
        check("R1 async reset clear", sum_q, 0);

        wd_done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule